// File: doc/BRIEF.md
# Dynamic Fill-Position Selector for a Cache Replacement Stack

This block decides, for every cache miss that triggers a fill, whether the incoming line is placed at the most-recently-used head of its set's recency order or at the least-recently-used tail. Two insertion strategies compete while the cache runs.

The first strategy always places a new line at the head. The second strategy places nearly every new line at the tail, so a line survives only if it is referenced again soon after arriving. It places a line at the head only on a rare pseudo-random draw.

A fixed subset of sets always uses the first strategy, and a second fixed subset always uses the second. Misses in each subset push a shared saturating counter in opposite directions. Every other set follows whichever strategy the counter currently favours.

The cache controller presents each lookup with a valid strobe, a miss flag and the set index. One cycle later it receives a registered head-or-tail decision for each miss. The recency stacks, tags and data are held elsewhere.

Top module: `ins_policy_sel`

## Requirements
- R1: A lookup with `acc_vld=1` and `acc_miss=1` produces `dec_vld=1` in the following cycle. A hit (`acc_miss=0`) or an idle cycle produces `dec_vld=0` in the following cycle.
- R2: A miss in a head-leader set always gives `dec_head=1`. A head-leader set is one whose set index has bits [4:0] equal to 0.
- R3: A miss in a tail-leader set gives `dec_head=1` exactly when bits [4:0] of the random generator are all zero in the cycle the request is sampled, and `dec_head=0` otherwise. A tail-leader set is one whose set index has bits [4:0] equal to 31.
- R4: The 10-bit selector counter increments by one on each miss in a head-leader set. It holds at 1023 instead of wrapping.
- R5: The selector counter decrements by one on each miss in a tail-leader set. It holds at 0 instead of wrapping.
- R6: Hits in any set leave the selector counter unchanged.
- R7: A miss in any other (follower) set uses the rule of R2 when selector bit 9 is 0, and the rule of R3 when selector bit 9 is 1. The selector value used is the one held before that same request updates it.
- R8: After reset, `dec_vld=0`, `dec_head=0`, the selector holds 511 (follower sets use head insertion), and the generator holds 16'hACE1.
- R9: The random generator is a 16-bit shift register that advances every cycle out of reset. It shifts left, and its new bit 0 is the XOR of bits 15, 13, 12 and 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Lookup strobe |
| acc_miss | input | 1 | Lookup missed and will be filled |
| acc_set | input | SET_W (10) | Set index of the lookup |
| dec_vld | output | 1 | Registered decision valid, one cycle after a miss |
| dec_head | output | 1 | 1: insert at MRU head, 0: insert at LRU tail |

## Verification
The embedded assertions check several rules on every cycle:
- the one-cycle decision timing;
- head placement for head-leader sets, and for follower sets while the selector favours the head strategy;
- the selector moving by at most one step, with no wrap;
- the selector staying put on hits;
- the generator never reaching the all-zero state.

Only the bench scenarios can show the rest, because each depends on long histories of misses. These are the exact saturation points of the counter, the point where the follower sets switch strategy as the counter crosses its midpoint, and the rare head placements under the tail strategy that match the generator sequence.

// File: rtl/ips_pkg.sv
package ips_pkg;
   typedef enum logic [1:0] {
      SET_FOLLOW   = 2'd0,
      SET_LDR_HEAD = 2'd1,
      SET_LDR_TAIL = 2'd2
   } set_role_e;
endpackage

// File: rtl/ips_leader_map.sv
module ips_leader_map #(
   parameter int GRP_LOG2     = 5,
   parameter int HEAD_LDR_OFS = 0,
   parameter int TAIL_LDR_OFS = 31
) (
   input  logic [GRP_LOG2-1:0] grp_ofs,
   output ips_pkg::set_role_e  role
);
   localparam logic [GRP_LOG2-1:0] HeadOfs = GRP_LOG2'(HEAD_LDR_OFS);
   localparam logic [GRP_LOG2-1:0] TailOfs = GRP_LOG2'(TAIL_LDR_OFS);

   if (HEAD_LDR_OFS == TAIL_LDR_OFS) begin : g_bad_ofs
      $error("leader offsets must differ");
   end
   if (HEAD_LDR_OFS >= (1 << GRP_LOG2) || TAIL_LDR_OFS >= (1 << GRP_LOG2)) begin : g_bad_range
      $error("leader offset outside group");
   end

   always_comb begin
      if (grp_ofs == HeadOfs)      role = ips_pkg::SET_LDR_HEAD;
      else if (grp_ofs == TailOfs) role = ips_pkg::SET_LDR_TAIL;
      else                         role = ips_pkg::SET_FOLLOW;
   end
endmodule

// File: rtl/ips_sat_ctr.sv
module ips_sat_ctr #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] CtrMax  = {W{1'b1}};
   localparam logic [W-1:0] CtrInit = {1'b0, {(W-1){1'b1}}};

   if (W < 2) begin : g_bad_w
      $error("selector width too small");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                      q <= CtrInit;
      else if (up && !dn && q != CtrMax) q <= q + 1'b1;
      else if (dn && !up && q != '0)   q <= q - 1'b1;
   end

   // R4 R5
   psel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q != $past(q)) |-> ((q == $past(q) + 1'b1 && q != '0) ||
                           (q == $past(q) - 1'b1 && q != CtrMax)));
endmodule

// File: rtl/ips_lfsr.sv
module ips_lfsr #(
   parameter int          W        = 16,
   parameter logic [W-1:0] SEED    = 16'hACE1,
   parameter int          DRAW_LOG2 = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic draw_hit
);
   logic [W-1:0] q;
   logic         fb;

   if (DRAW_LOG2 < 1 || DRAW_LOG2 > W) begin : g_bad_draw
      $error("draw width outside register");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("seed must be nonzero");
   end

   if (W == 16) begin : g_taps16
      assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];
   end else if (W == 8) begin : g_taps8
      assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];
   end else begin : g_taps_bad
      assign fb = 1'b0;
      $error("unsupported generator width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= SEED;
      else        q <= {q[W-2:0], fb};
   end

   assign draw_hit = (q[DRAW_LOG2-1:0] == '0);

   // R9
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);
endmodule

// File: rtl/ins_policy_sel.sv
module ins_policy_sel #(
   parameter int SET_W        = 10,
   parameter int PSEL_W       = 10,
   parameter int GRP_LOG2     = 5,
   parameter int HEAD_LDR_OFS = 0,
   parameter int TAIL_LDR_OFS = 31,
   parameter int LFSR_W       = 16,
   parameter int DRAW_LOG2    = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_vld,
   input  logic             acc_miss,
   input  logic [SET_W-1:0] acc_set,
   output logic             dec_vld,
   output logic             dec_head
);
   import ips_pkg::*;

   localparam int PselMsb = PSEL_W - 1;

   if (SET_W <= GRP_LOG2) begin : g_bad_sets
      $error("set index must exceed group width");
   end

   set_role_e         role;
   logic              miss_evt;
   logic              draw_hit;
   logic [PSEL_W-1:0] psel;
   logic              head_nxt;
   logic              set_hi_unused;

   assign set_hi_unused = ^acc_set[SET_W-1:GRP_LOG2];
   assign miss_evt      = acc_vld && acc_miss;

   ips_leader_map #(
      .GRP_LOG2    (GRP_LOG2),
      .HEAD_LDR_OFS(HEAD_LDR_OFS),
      .TAIL_LDR_OFS(TAIL_LDR_OFS)
   ) u_map (
      .grp_ofs(acc_set[GRP_LOG2-1:0]),
      .role   (role)
   );

   ips_sat_ctr #(.W(PSEL_W)) u_psel (
      .clk  (clk),
      .rst_n(rst_n),
      .up   (miss_evt && role == SET_LDR_HEAD),
      .dn   (miss_evt && role == SET_LDR_TAIL),
      .q    (psel)
   );

   ips_lfsr #(
      .W        (LFSR_W),
      .SEED     (LFSR_W'(16'hACE1)),
      .DRAW_LOG2(DRAW_LOG2)
   ) u_rng (
      .clk     (clk),
      .rst_n   (rst_n),
      .draw_hit(draw_hit)
   );

   always_comb begin
      unique case (role)
         SET_LDR_HEAD: head_nxt = 1'b1;
         SET_LDR_TAIL: head_nxt = draw_hit;
         default:      head_nxt = psel[PselMsb] ? draw_hit : 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_vld  <= 1'b0;
         dec_head <= 1'b0;
      end else begin
         dec_vld  <= miss_evt;
         if (miss_evt) dec_head <= head_nxt;
      end
   end

   // R1
   dec_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld == $past(miss_evt));

   // R2
   head_ldr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_evt && role == SET_LDR_HEAD) |=> dec_head);

   // R6
   hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_miss) |=> $stable(psel));

   // R7
   follow_mru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_evt && role == SET_FOLLOW && !psel[PselMsb]) |=> dec_head);
endmodule

// File: tb/tb_ins_policy_sel.sv
`timescale 1ns/1ps
module tb_ins_policy_sel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_vld = 1'b0;
   logic       acc_miss = 1'b0;
   logic [9:0] acc_set = '0;
   logic       dec_vld;
   logic       dec_head;

   int checks = 0;
   int fails  = 0;

   logic [15:0] lfsr_m;
   int          psel_m;

   always #2 clk = ~clk;

   ins_policy_sel dut (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_miss(acc_miss),
      .acc_set(acc_set), .dec_vld(dec_vld), .dec_head(dec_head)
   );

   always @(posedge clk) begin
      if (!rst_n) lfsr_m <= 16'hACE1;
      else        lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
   end

   task automatic check(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   function automatic logic exp_head(logic [9:0] s, int p, logic [15:0] r);
      logic draw;
      draw = (r[4:0] == 5'd0);
      if (s[4:0] == 5'd0)       return 1'b1;
      else if (s[4:0] == 5'd31) return draw;
      else                      return (p >= 512) ? draw : 1'b1;
   endfunction

   // called at a negedge; checks at the following negedge
   task automatic access(logic [9:0] s, logic miss, string req);
      logic eh;
      eh = exp_head(s, psel_m, lfsr_m);
      acc_vld = 1'b1; acc_miss = miss; acc_set = s;
      @(posedge clk);
      if (miss && s[4:0] == 5'd0 && psel_m < 1023) psel_m++;
      if (miss && s[4:0] == 5'd31 && psel_m > 0)   psel_m--;
      @(negedge clk);
      acc_vld = 1'b0; acc_miss = 1'b0;
      check({req, " vld"}, dec_vld, miss);
      if (miss) check({req, " head"}, dec_head, eh);
   endtask

   task automatic probe_followers(int n, string req);
      for (int i = 0; i < n; i++) access(10'(33 + (i % 30) + 32 * (i % 7)), 1'b1, req);
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      psel_m = 511;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 reset dec_vld", dec_vld, 1'b0);
      check("R8 reset dec_head", dec_head, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle after reset", dec_vld, 1'b0);
      // R8: followers start with head insertion
      probe_followers(8, "R8 R7 initial follower");

      // R1 R2 R3 R7 R9: sweep every set with a miss
      for (int s = 0; s < 1024; s++) access(10'(s), 1'b1, "R1 R2 R3 R7 R9 sweep miss");
      // R1 R6: sweep every set with a hit
      for (int s = 0; s < 1024; s++) access(10'(s), 1'b0, "R1 R6 sweep hit");
      probe_followers(16, "R6 after hit sweep");

      // R4: drive to the top, beyond saturation
      for (int i = 0; i < 600; i++) access(10'd32, 1'b1, "R2 head leader");
      probe_followers(64, "R4 R7 follower at top");
      for (int i = 0; i < 511; i++) access(10'd63, 1'b1, "R3 R9 tail leader");
      probe_followers(64, "R4 follower at 512");
      access(10'd95, 1'b1, "R3 tail leader");
      probe_followers(16, "R4 R7 follower at 511");

      // R5: drive to the bottom, beyond saturation
      for (int i = 0; i < 600; i++) access(10'd127, 1'b1, "R5 R3 tail leader");
      access(10'd64, 1'b1, "R2 head leader");
      probe_followers(16, "R5 follower at 1");
      for (int i = 0; i < 511; i++) access(10'd96, 1'b1, "R5 R2 head leader");
      probe_followers(64, "R5 R7 follower at 512");

      // R6: hits on leaders leave the selector alone
      for (int i = 0; i < 40; i++) access(10'd127, 1'b0, "R6 hit tail leader");
      probe_followers(64, "R6 follower after leader hits");
      for (int i = 0; i < 40; i++) access(10'd31, 1'b1, "R3 tail leader");
      for (int i = 0; i < 40; i++) access(10'd0, 1'b0, "R6 hit head leader");
      probe_followers(32, "R6 R7 follower after hits");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule